// File: doc/BRIEF.md
# Dual Gated 2-to-4 Decoder/Demultiplexer

This block holds two one-hot decoder sections that read the same binary address. Each section drives four active-low select lines and has its own two-input enable gate. Section A opens when its positive enable is 1 and its negative enable is 0. Because of this, a data stream placed on either pin of section A appears on the addressed line, either inverted or true. Section B opens only when both of its negative enables are 0. When a section is closed, all four of its lines stay high.

A mode input joins the two sections into a single one-of-eight decoder. In this mode a third address bit drives section A's positive enable and one of section B's negative enables. A shared negative enable drives the two remaining enable pins. The direct enable pins are then ignored.

A mask output models open-collector lines tied together with a pull-up. It reports the AND of whichever select lines the mask picks.

The whole block is combinational and has no clock or reset.

Top module: `twin_decoder`

## Requirements
- R1: `addr` is a binary-weighted index (`addr[0]` is the least significant bit), and both sections decode the same value.
- R2: When `aEnHi`=1 and `aEnLoN`=0 (dual mode), `outN[addr]` is 0 and the other three bits of `outN[3:0]` are 1.
- R3: In dual mode, when the condition of R2 is not met, `outN[3:0]` is 4'hF for every address.
- R4: When `bEnN`=2'b00 (dual mode), `outN[4+addr]` is 0 and the other three bits of `outN[7:4]` are 1.
- R5: In dual mode, when either bit of `bEnN` is 1, `outN[7:4]` is 4'hF for every address.
- R6: With `aEnLoN`=0, the addressed line of section A equals the inverse of the data on `aEnHi`. With `aEnHi`=1, the addressed line equals the data on `aEnLoN`.
- R7: When `mode8`=1, `addr2` takes the place of `aEnHi` and `bEnN[0]`, and `joinEnN` takes the place of `aEnLoN` and `bEnN[1]`. The direct pins `aEnHi`, `aEnLoN` and `bEnN` then have no effect on `outN`.
- R8: With `mode8`=1 and `joinEnN`=0, exactly one line is low: `outN[addr]` when `addr2`=1, and `outN[4+addr]` when `addr2`=0. With `joinEnN`=1, `outN` is 8'hFF.
- R9: `dotOut` is the AND of the bits `outN[i]` for which `dotMask[i]`=1. It is 1 when `dotMask` is 0.
- R10: No section ever drives more than one of its lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 2 | Shared binary address |
| aEnHi | input | 1 | Section A positive enable (dual mode) |
| aEnLoN | input | 1 | Section A negative enable (dual mode) |
| bEnN | input | 2 | Section B negative enables (dual mode) |
| mode8 | input | 1 | 1 joins the sections into one-of-eight |
| addr2 | input | 1 | Third address bit in joined mode |
| joinEnN | input | 1 | Shared negative enable in joined mode |
| dotMask | input | 8 | Selects the lines tied into `dotOut` |
| outN | output | 8 | Active-low lines; [3:0] section A, [7:4] section B |
| dotOut | output | 1 | Wired-AND of the masked lines |

## Verification
Every result of this block is due in the same cycle as its stimulus, since no register lies between any input and `outN` or `dotOut`. The bench changes inputs on the rising edge and reads the outputs at the following falling edge, half a period later. This leaves the combinational paths time to settle before any comparison. In dual mode all 64 combinations of address and enable pins are swept against a model in the bench. The joined mode, the data-routing cases and the mask are then covered by directed vectors.

// File: rtl/twin_decoder_pkg.sv
package twin_decoder_pkg;
  typedef struct packed {
    logic secAEn;
    logic secBEn;
  } enStrobe_t;
endpackage

// File: rtl/twin_decoder_ctl.sv
module twin_decoder_ctl
  import twin_decoder_pkg::*;
(
  input  logic      aEnHi,
  input  logic      aEnLoN,
  input  logic [1:0] bEnN,
  input  logic      mode8,
  input  logic      addr2,
  input  logic      joinEnN,
  output enStrobe_t strobe
);
  logic gateAHi, gateALoN, gateBN0, gateBN1;

  always_comb begin
    if (mode8) begin
      gateAHi  = addr2;
      gateBN0  = addr2;
      gateALoN = joinEnN;
      gateBN1  = joinEnN;
    end else begin
      gateAHi  = aEnHi;
      gateALoN = aEnLoN;
      gateBN0  = bEnN[0];
      gateBN1  = bEnN[1];
    end
    strobe.secAEn = gateAHi & ~gateALoN;
    strobe.secBEn = ~gateBN0 & ~gateBN1;
  end
endmodule

// File: rtl/twin_decoder_dp.sv
module twin_decoder_dp
  import twin_decoder_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int SEC_OUTS = 1 << ADDR_W,
  localparam int ALL_OUTS = 2 * SEC_OUTS
) (
  input  logic [ADDR_W-1:0]   addr,
  input  enStrobe_t           strobe,
  input  logic [ALL_OUTS-1:0] dotMask,
  output logic [ALL_OUTS-1:0] outN,
  output logic                dotOut
);
  logic [1:0] secEn;
  assign secEn = {strobe.secBEn, strobe.secAEn};

  for (genvar s = 0; s < 2; s++) begin : g_sec
    for (genvar k = 0; k < SEC_OUTS; k++) begin : g_line
      assign outN[s*SEC_OUTS + k] = ~(secEn[s] && (addr == ADDR_W'(k)));
    end
  end

  assign dotOut = &(outN | ~dotMask);
endmodule

// File: rtl/twin_decoder.sv
module twin_decoder
  import twin_decoder_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int ALL_OUTS = 2 * (1 << ADDR_W)
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                aEnHi,
  input  logic                aEnLoN,
  input  logic [1:0]          bEnN,
  input  logic                mode8,
  input  logic                addr2,
  input  logic                joinEnN,
  input  logic [ALL_OUTS-1:0] dotMask,
  output logic [ALL_OUTS-1:0] outN,
  output logic                dotOut
);
  enStrobe_t strobe;

  twin_decoder_ctl u_ctl (
    .aEnHi(aEnHi), .aEnLoN(aEnLoN), .bEnN(bEnN), .mode8(mode8),
    .addr2(addr2), .joinEnN(joinEnN), .strobe(strobe)
  );

  twin_decoder_dp #(.ADDR_W(ADDR_W)) u_dp (
    .addr(addr), .strobe(strobe), .dotMask(dotMask),
    .outN(outN), .dotOut(dotOut)
  );
endmodule

// File: rtl/twin_decoder_chk.sv
module twin_decoder_chk #(
  parameter int ADDR_W = 2,
  localparam int SEC_OUTS = 1 << ADDR_W,
  localparam int ALL_OUTS = 2 * SEC_OUTS
) (
  input logic [ADDR_W-1:0]   addr,
  input logic                aEnHi,
  input logic                aEnLoN,
  input logic [1:0]          bEnN,
  input logic                mode8,
  input logic                addr2,
  input logic                joinEnN,
  input logic [ALL_OUTS-1:0] dotMask,
  input logic [ALL_OUTS-1:0] outN,
  input logic                dotOut
);
  logic [SEC_OUTS-1:0] loA, loB;
  assign loA = ~outN[SEC_OUTS-1:0];
  assign loB = ~outN[ALL_OUTS-1:SEC_OUTS];

  always_comb begin
    AST_A_ONE_LOW: assert ($countones(loA) <= 1);                          // R10
    AST_B_ONE_LOW: assert ($countones(loB) <= 1);                          // R10
    AST_A_CLOSED:  assert (mode8 || (aEnHi && !aEnLoN) || loA == '0);      // R3
    AST_B_CLOSED:  assert (mode8 || bEnN == 2'b00 || loB == '0);           // R5
    AST_OCT_ONE:   assert (!mode8 || $countones(~outN) <= 1);              // R8
    AST_OCT_OFF:   assert (!mode8 || !joinEnN || outN == '1);              // R8
    AST_DOT_EMPTY: assert (dotMask != '0 || dotOut);                       // R9
    AST_DOT_LOW:   assert ((dotMask & ~outN) == '0 || !dotOut);            // R9
  end
endmodule

bind twin_decoder twin_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .addr(addr), .aEnHi(aEnHi), .aEnLoN(aEnLoN), .bEnN(bEnN), .mode8(mode8),
  .addr2(addr2), .joinEnN(joinEnN), .dotMask(dotMask), .outN(outN), .dotOut(dotOut)
);

// File: tb/sim_twin_decoder.sv
module sim_twin_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] addr;
  logic       aEnHi, aEnLoN, mode8, addr2, joinEnN;
  logic [1:0] bEnN;
  logic [7:0] dotMask, outN;
  logic       dotOut;
  int total = 0;
  int bad = 0;
  bit done = 0;

  twin_decoder u0 (
    .addr(addr), .aEnHi(aEnHi), .aEnLoN(aEnLoN), .bEnN(bEnN), .mode8(mode8),
    .addr2(addr2), .joinEnN(joinEnN), .dotMask(dotMask), .outN(outN), .dotOut(dotOut)
  );

  // Vector: {mode8, addr2, joinEnN, aEnHi, aEnLoN, bEnN[1:0], addr[1:0], expected outN}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'd2, 8'hBB}, // R2 R4 both open
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 2'd3, 8'hFF}, // R3 R5 both closed
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 2'd1, 8'hFD}, // R2 R5
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 2'd0, 8'hEF}, // R3 R4
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'd3, 8'hF7}, // R7 R8 pins ignored
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 8'hEF}, // R7 R8
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 2'd2, 8'hFF}, // R8 shared enable off
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'd3, 8'h7F}  // R8 top line
  };

  function automatic logic [7:0] model(input logic [1:0] ad, input logic hi, input logic loN,
                                       input logic [1:0] bn, input logic m8, input logic a2,
                                       input logic jn);
    logic openA, openB;
    logic [7:0] r;
    openA = m8 ? (a2 == 1'b1 && jn == 1'b0) : (hi == 1'b1 && loN == 1'b0);
    openB = m8 ? (a2 == 1'b0 && jn == 1'b0) : (bn == 2'b00);
    r = 8'hFF;
    if (openA) r[ad] = 1'b0;
    if (openB) r[4 + ad] = 1'b0;
    return r;
  endfunction

  task automatic drive(input logic [1:0] ad, input logic hi, input logic loN, input logic [1:0] bn,
                       input logic m8, input logic a2, input logic jn, input logic [7:0] mk);
    @(posedge clk);
    addr = ad; aEnHi = hi; aEnLoN = loN; bEnN = bn; mode8 = m8; addr2 = a2; joinEnN = jn;
    dotMask = mk;
    @(negedge clk);
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    addr = '0; aEnHi = 0; aEnLoN = 1; bEnN = 2'b11; mode8 = 0; addr2 = 0; joinEnN = 1;
    dotMask = '0;
    @(negedge clk);
    check8("R3 R5 idle state all high", outN, 8'hFF);
    check8("R9 empty mask idle", {7'd0, dotOut}, 8'd1);

    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][9:8], VEC[i][13], VEC[i][12], VEC[i][11:10], VEC[i][16], VEC[i][15],
            VEC[i][14], 8'h00);
      check8("R2 R4 R7 R8 table", outN, VEC[i][7:0]);
      check8("R9 empty mask", {7'd0, dotOut}, 8'd1);
    end

    // R1 R2 R3 R4 R5 R10: every dual-mode combination of address and enables
    for (int v = 0; v < 64; v++) begin
      logic [5:0] b;
      b = 6'(v);
      drive(b[1:0], b[2], b[3], b[5:4], 1'b0, 1'b0, 1'b0, 8'h00);
      check8("R1-sweep R2 R3 R4 R5", outN, model(b[1:0], b[2], b[3], b[5:4], 1'b0, 1'b0, 1'b0));
    end

    // R7 R8: joined mode with the direct pins scrambled
    for (int v = 0; v < 32; v++) begin
      logic [4:0] b;
      b = 5'(v);
      drive(b[1:0], ~b[0], b[1], ~b[1:0], 1'b1, b[2], b[3], 8'h00);
      check8("R7 R8 joined sweep", outN, model(b[1:0], 1'b0, 1'b1, 2'b11, 1'b1, b[2], b[3]));
    end

    // R6: data on the positive pin arrives inverted, on the negative pin true
    drive(2'd1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h00);
    check8("R6 data 1 on aEnHi", {7'd0, outN[1]}, 8'd0);
    drive(2'd1, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h00);
    check8("R6 data 0 on aEnHi", {7'd0, outN[1]}, 8'd1);
    drive(2'd3, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'h00);
    check8("R6 data 1 on aEnLoN", {7'd0, outN[3]}, 8'd1);
    drive(2'd3, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h00);
    check8("R6 data 0 on aEnLoN", {7'd0, outN[3]}, 8'd0);

    // R9: mask covering the low line pulls the dot low, otherwise high
    drive(2'd2, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'h04);
    check8("R9 mask hits low line", {7'd0, dotOut}, 8'd0);
    drive(2'd2, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'hBB);
    check8("R9 mask avoids low lines", {7'd0, dotOut}, 8'd1);
    drive(2'd2, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'h40);
    check8("R9 mask hits section B line", {7'd0, dotOut}, 8'd0);
    drive(2'd0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'hFF);
    check8("R9 full mask all closed", {7'd0, dotOut}, 8'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule